// File: doc/BRIEF.md
# Chunk Ring Queue with Windowed Reserve and Commit

This block is a hardware queue whose storage is a ring of `NCH` fixed-size chunks. A chunk is the smallest unit that is allocated, filled, handed to a consumer and released. A producer has two ways to add data. It can push one finished chunk in a single step. It can also claim a window of several contiguous chunks, write into them, and commit any part of that window later. Commits may arrive out of order. A chunk reaches consumers only when every chunk before it has also been committed.

Four pointers carry the state. Each pointer has one wrap bit above its index bits:

- The alloc pointer marks the next chunk a producer can claim.
- The tail pointer marks the end of the committed run.
- The read pointer marks the next chunk a consumer can claim.
- The reclaim pointer marks the oldest chunk not yet released.

Each chunk also has a done flag. The tail pointer walks forward over done chunks and clears each flag as it passes.

Consumers claim windows of committed chunks and read them through a direct index port. They then release chunks in order, which frees storage for new claims. Every claim returns the index of its first chunk and a window identifier. A request that cannot be met is never partly granted. Its ready output stays low, and the requester stalls.

Top module: `chunk_ring_queue`

## Requirements
- R1: After reset all four pointers are zero. `q_empty` is 1, `q_full` is 0 and `push_ready` is 1.
- R2: When `push_valid` is high and at least one chunk is free, `push_ready` is high. At the clock edge, `push_data` is stored in the chunk at the alloc index, that chunk is marked done and the alloc pointer advances by one. While `push_valid` is high, `prsv_ready` is low.
- R3: `prsv_ready` is high exactly when `push_valid` is low and 1 <= `prsv_num` <= free. Here free is `NCH` minus (alloc − reclaim). A grant reports `prsv_start` = alloc index and `prsv_id` = the number of earlier producer grants modulo 2^`IDW`. The grant then advances the alloc pointer by exactly `prsv_num`.
- R4: A refused claim (ready low) changes no pointer and no identifier.
- R5: `wr_en` stores `wr_data` into chunk `wr_idx` only if that chunk lies between tail and alloc and its done flag is clear. Otherwise the write is ignored.
- R6: `pcmt_ready` is high exactly when `pcmt_num` >= 1 and ((`pcmt_start` − tail index) mod `NCH`) + `pcmt_num` <= alloc − tail. A commit marks those chunks done.
- R7: The tail pointer advances by one chunk per clock while the chunk at tail is done and tail differs from alloc. A chunk whose predecessor is not yet committed therefore stays hidden from consumers.
- R8: `crsv_ready` is high exactly when 1 <= `crsv_num` <= tail − read. A grant reports `crsv_start` = read index and `crsv_id` = the number of earlier consumer grants modulo 2^`IDW`. The read pointer then advances by `crsv_num`.
- R9: `crel_ready` is high exactly when 1 <= `crel_num` <= read − reclaim. A release advances the reclaim pointer by `crel_num`, which frees that many chunks.
- R10: Indices wrap modulo `NCH`. `q_full` is 1 exactly when alloc − reclaim = `NCH`. `q_empty` is 1 exactly when tail = read.
- R11: `rd_data` always shows the content of chunk `rd_idx`, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Push one finished chunk |
| push_data | input | CW | Chunk content for a push |
| push_ready | output | 1 | A free chunk exists |
| prsv_valid | input | 1 | Producer window claim |
| prsv_num | input | log2(NCH)+1 | Chunks asked by the producer |
| prsv_ready | output | 1 | Producer claim can be granted |
| prsv_start | output | log2(NCH) | First chunk of the producer window |
| prsv_id | output | IDW | Producer window identifier |
| wr_en | input | 1 | Write into a claimed chunk |
| wr_idx | input | log2(NCH) | Chunk written |
| wr_data | input | CW | Chunk content written |
| pcmt_valid | input | 1 | Commit a chunk range |
| pcmt_start | input | log2(NCH) | First chunk committed |
| pcmt_num | input | log2(NCH)+1 | Chunks committed |
| pcmt_ready | output | 1 | Commit range is valid |
| crsv_valid | input | 1 | Consumer window claim |
| crsv_num | input | log2(NCH)+1 | Chunks asked by the consumer |
| crsv_ready | output | 1 | Consumer claim can be granted |
| crsv_start | output | log2(NCH) | First chunk of the consumer window |
| crsv_id | output | IDW | Consumer window identifier |
| rd_idx | input | log2(NCH) | Chunk read |
| rd_data | output | CW | Content of chunk `rd_idx` |
| crel_valid | input | 1 | Release chunks |
| crel_num | input | log2(NCH)+1 | Chunks released |
| crel_ready | output | 1 | Release count is valid |
| q_full | output | 1 | Every chunk is claimed or held |
| q_empty | output | 1 | No committed chunk awaits a consumer |

## Verification
The following outputs depend only on the current state and inputs, so they are valid in the same cycle a request is driven:

- every ready output
- `prsv_start`, `prsv_id`, `crsv_start` and `crsv_id`
- `rd_data`

Pointer moves, stored data and done flags take effect at the next rising edge. A committed or pushed chunk reaches consumers one edge after that, because the tail walks one further edge per chunk.

The bench drives at the falling edge and checks readiness and window fields shortly after. It checks pointer effects at the following falling edge. For each tail step it checks once before and once after the edge, so an early or late walk is caught. Readiness sweeps cover every count from 0 to 7 at several fill levels and compare against free, committed and held counts that the bench tracks itself.

// File: rtl/chunk_ring_queue.sv
module chunk_ring_queue #(
  parameter int NCH = 8,
  parameter int CW  = 32,
  parameter int IDW = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push_valid,
  input  logic [CW-1:0]          push_data,
  output logic                   push_ready,
  input  logic                   prsv_valid,
  input  logic [$clog2(NCH):0]   prsv_num,
  output logic                   prsv_ready,
  output logic [$clog2(NCH)-1:0] prsv_start,
  output logic [IDW-1:0]         prsv_id,
  input  logic                   wr_en,
  input  logic [$clog2(NCH)-1:0] wr_idx,
  input  logic [CW-1:0]          wr_data,
  input  logic                   pcmt_valid,
  input  logic [$clog2(NCH)-1:0] pcmt_start,
  input  logic [$clog2(NCH):0]   pcmt_num,
  output logic                   pcmt_ready,
  input  logic                   crsv_valid,
  input  logic [$clog2(NCH):0]   crsv_num,
  output logic                   crsv_ready,
  output logic [$clog2(NCH)-1:0] crsv_start,
  output logic [IDW-1:0]         crsv_id,
  input  logic [$clog2(NCH)-1:0] rd_idx,
  output logic [CW-1:0]          rd_data,
  input  logic                   crel_valid,
  input  logic [$clog2(NCH):0]   crel_num,
  output logic                   crel_ready,
  output logic                   q_full,
  output logic                   q_empty
);
  localparam int IW = $clog2(NCH);
  localparam int PW = IW + 1;
  localparam logic [PW-1:0] DEPTH = PW'(NCH);

  logic [PW-1:0]  head, tail, rdp, recl;
  logic [NCH-1:0] done, cmt_mask, push_mask, clr_mask;
  logic [CW-1:0]  mem [NCH];
  logic [IDW-1:0] pid, cid;

  wire [PW-1:0] used   = head - recl;
  wire [PW-1:0] free_c = DEPTH - used;
  wire [PW-1:0] open_c = head - tail;
  wire [PW-1:0] avail  = tail - rdp;
  wire [PW-1:0] held   = rdp - recl;
  wire [IW-1:0] cofs   = pcmt_start - tail[IW-1:0];
  wire [IW-1:0] wofs   = wr_idx - tail[IW-1:0];

  assign push_ready = free_c != '0;
  assign prsv_ready = !push_valid && prsv_num != '0 && prsv_num <= free_c;
  assign pcmt_ready = pcmt_num != '0 &&
                      ((PW+1)'(cofs) + (PW+1)'(pcmt_num)) <= (PW+1)'(open_c);
  assign crsv_ready = crsv_num != '0 && crsv_num <= avail;
  assign crel_ready = crel_num != '0 && crel_num <= held;

  wire push_go = push_valid && push_ready;
  wire prsv_go = prsv_valid && prsv_ready;
  wire pcmt_go = pcmt_valid && pcmt_ready;
  wire crsv_go = crsv_valid && crsv_ready;
  wire crel_go = crel_valid && crel_ready;
  wire wr_ok   = wr_en && (PW'(wofs) < open_c) && !done[wr_idx];
  wire step    = (tail != head) && done[tail[IW-1:0]];

  assign prsv_start = head[IW-1:0];
  assign prsv_id    = pid;
  assign crsv_start = rdp[IW-1:0];
  assign crsv_id    = cid;
  assign rd_data    = mem[rd_idx];
  assign q_full     = used == DEPTH;
  assign q_empty    = avail == '0;

  always_comb begin
    cmt_mask  = '0;
    push_mask = '0;
    clr_mask  = '0;
    for (int i = 0; i < NCH; i++)
      if (pcmt_go && PW'(IW'(i) - pcmt_start) < pcmt_num) cmt_mask[i] = 1'b1;
    if (push_go) push_mask[head[IW-1:0]] = 1'b1;
    if (step)    clr_mask[tail[IW-1:0]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      rdp  <= '0;
      recl <= '0;
      done <= '0;
      pid  <= '0;
      cid  <= '0;
    end else begin
      head <= head + (push_go ? PW'(1) : (prsv_go ? prsv_num : '0));
      tail <= tail + PW'(step);
      rdp  <= rdp + (crsv_go ? crsv_num : '0);
      recl <= recl + (crel_go ? crel_num : '0);
      done <= (done | cmt_mask | push_mask) & ~clr_mask;
      pid  <= pid + IDW'(prsv_go);
      cid  <= cid + IDW'(crsv_go);
    end
  end

  always_ff @(posedge clk) begin
    if (push_go) mem[head[IW-1:0]] <= push_data;
    if (wr_ok)   mem[wr_idx] <= wr_data;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    used <= DEPTH);                                                      // R10
  AST_PTR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    held <= PW'(tail - recl) && PW'(tail - recl) <= used);                // R8
  AST_RSV_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
    prsv_valid && prsv_ready |=> PW'(head - $past(head)) == $past(prsv_num)); // R3
  AST_RSV_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    prsv_valid && !prsv_ready && !push_valid |=> $stable(head) && $stable(pid)); // R4
  AST_TAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> PW'(tail - $past(tail)) <= PW'(1));                          // R7
  AST_RECLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    crel_valid && crel_ready |=> PW'(recl - $past(recl)) == $past(crel_num)); // R9
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !push_ready && !prsv_ready);                               // R10
endmodule

// File: tb/tb_chunk_ring_queue.sv
module tb_chunk_ring_queue;
  localparam int NCH = 4;
  localparam int CW  = 8;
  localparam int IDW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_valid = 0, prsv_valid = 0, wr_en = 0, pcmt_valid = 0, crsv_valid = 0, crel_valid = 0;
  logic [CW-1:0] push_data = '0, wr_data = '0, rd_data;
  logic [2:0] prsv_num = '0, pcmt_num = '0, crsv_num = '0, crel_num = '0;
  logic [1:0] wr_idx = '0, pcmt_start = '0, rd_idx = '0, prsv_start, crsv_start;
  logic [IDW-1:0] prsv_id, crsv_id;
  logic push_ready, prsv_ready, pcmt_ready, crsv_ready, crel_ready, q_full, q_empty;

  int total = 0, bad = 0, hm = 0, tm = 0, cm = 0, rm = 0;
  bit fin = 0;

  always #10 clk = ~clk;

  chunk_ring_queue #(.NCH(NCH), .CW(CW), .IDW(IDW)) dut (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
    .prsv_valid(prsv_valid), .prsv_num(prsv_num), .prsv_ready(prsv_ready),
    .prsv_start(prsv_start), .prsv_id(prsv_id),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pcmt_valid(pcmt_valid), .pcmt_start(pcmt_start), .pcmt_num(pcmt_num), .pcmt_ready(pcmt_ready),
    .crsv_valid(crsv_valid), .crsv_num(crsv_num), .crsv_ready(crsv_ready),
    .crsv_start(crsv_start), .crsv_id(crsv_id),
    .rd_idx(rd_idx), .rd_data(rd_data),
    .crel_valid(crel_valid), .crel_num(crel_num), .crel_ready(crel_ready),
    .q_full(q_full), .q_empty(q_empty));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    push_valid = 0; prsv_valid = 0; wr_en = 0; pcmt_valid = 0; crsv_valid = 0; crel_valid = 0;
  endtask

  task automatic go();
    @(posedge clk); #1 clr();
    @(negedge clk);
  endtask

  task automatic sweep();
    for (int n = 0; n < 8; n++) begin
      prsv_num = 3'(n); crsv_num = 3'(n); crel_num = 3'(n);
      #1;
      chk($sformatf("R3 prsv_ready n=%0d", n), prsv_ready, int'(n >= 1 && n <= NCH - (hm - rm)));
      chk($sformatf("R8 crsv_ready n=%0d", n), crsv_ready, int'(n >= 1 && n <= tm - cm));
      chk($sformatf("R9 crel_ready n=%0d", n), crel_ready, int'(n >= 1 && n <= cm - rm));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 q_empty", q_empty, 1);
    chk("R1 q_full", q_full, 0);
    chk("R1 push_ready", push_ready, 1);
    sweep();

    push_valid = 1; push_data = 8'h11; prsv_valid = 1; prsv_num = 1; #1;
    chk("R2 push_ready", push_ready, 1);
    chk("R2 prsv_ready low under push", prsv_ready, 0);
    go(); hm = 1;
    chk("R7 empty before tail step", q_empty, 1);
    go(); tm = 1;
    chk("R7 visible after tail step", q_empty, 0);

    prsv_valid = 1; prsv_num = 2; #1;
    chk("R3 grant ready", prsv_ready, 1);
    chk("R3 grant start", prsv_start, 1);
    chk("R3 grant id", prsv_id, 0);
    go(); hm = 3;
    prsv_valid = 1; prsv_num = 2; #1;
    chk("R4 refuse ready", prsv_ready, 0);
    go();
    prsv_valid = 1; prsv_num = 1; #1;
    chk("R4 start unchanged", prsv_start, 3);
    chk("R4 id unchanged", prsv_id, 1);
    go(); hm = 4;
    chk("R10 full", q_full, 1);
    chk("R10 push stall", push_ready, 0);
    sweep();

    wr_en = 1; wr_idx = 1; wr_data = 8'hA1; go();
    wr_en = 1; wr_idx = 2; wr_data = 8'hA2; go();
    wr_en = 1; wr_idx = 3; wr_data = 8'hA3; go();
    wr_en = 1; wr_idx = 0; wr_data = 8'hFF; go();

    pcmt_valid = 1; pcmt_start = 3; pcmt_num = 1; #1;
    chk("R6 commit ready", pcmt_ready, 1);
    go();
    pcmt_valid = 1; pcmt_start = 0; pcmt_num = 1;
    wr_en = 1; wr_idx = 3; wr_data = 8'hEE; #1;
    chk("R6 commit outside refused", pcmt_ready, 0);
    pcmt_start = 2; pcmt_num = 3; #1;
    chk("R6 commit overrun refused", pcmt_ready, 0);
    go(); go(); go();
    crsv_num = 2; #1;
    chk("R7 gap holds tail", crsv_ready, 0);

    pcmt_valid = 1; pcmt_start = 1; pcmt_num = 2; #1;
    chk("R6 commit range", pcmt_ready, 1);
    go();
    crsv_num = 2; #1;
    chk("R7 tail step 1 pending", crsv_ready, 0);
    go();
    crsv_num = 2; #1; chk("R7 tail step 1", crsv_ready, 1);
    crsv_num = 3; #1; chk("R7 tail step 2 pending", crsv_ready, 0);
    go();
    crsv_num = 3; #1; chk("R7 tail step 2", crsv_ready, 1);
    crsv_num = 4; #1; chk("R7 tail step 3 pending", crsv_ready, 0);
    go(); tm = 4;
    crsv_num = 4; #1; chk("R7 tail step 3", crsv_ready, 1);

    crsv_valid = 1; crsv_num = 3; #1;
    chk("R8 consumer start", crsv_start, 0);
    chk("R8 consumer id", crsv_id, 0);
    go(); cm = 3;
    rd_idx = 0; #1; chk("R5 ignored write chunk0", rd_data, 8'h11);
    rd_idx = 1; #1; chk("R11 read chunk1", rd_data, 8'hA1);
    rd_idx = 2; #1; chk("R11 read chunk2", rd_data, 8'hA2);
    rd_idx = 3; #1; chk("R5 ignored write done chunk3", rd_data, 8'hA3);
    sweep();

    crel_valid = 1; crel_num = 4; #1;
    chk("R9 over-release refused", crel_ready, 0);
    crel_num = 2; #1;
    chk("R9 release ready", crel_ready, 1);
    go(); rm = 2;
    chk("R9 space freed", q_full, 0);
    sweep();

    prsv_valid = 1; prsv_num = 2; #1;
    chk("R10 wrap start", prsv_start, 0);
    chk("R3 id count", prsv_id, 2);
    go(); hm = 6;
    chk("R10 full after wrap", q_full, 1);
    wr_en = 1; wr_idx = 0; wr_data = 8'hB0; go();
    wr_en = 1; wr_idx = 1; wr_data = 8'hB1; go();
    pcmt_valid = 1; pcmt_start = 0; pcmt_num = 2; #1;
    chk("R6 wrapped commit", pcmt_ready, 1);
    go(); go(); go(); tm = 6;
    crsv_valid = 1; crsv_num = 1; #1;
    chk("R8 start 3", crsv_start, 3);
    chk("R8 id 1", crsv_id, 1);
    go(); cm = 4;
    crsv_valid = 1; crsv_num = 2; #1;
    chk("R10 consumer wrap start", crsv_start, 0);
    chk("R8 id 2", crsv_id, 2);
    go(); cm = 6;
    rd_idx = 0; #1; chk("R11 wrapped chunk0", rd_data, 8'hB0);
    rd_idx = 1; #1; chk("R11 wrapped chunk1", rd_data, 8'hB1);
    chk("R10 empty", q_empty, 1);
    crel_valid = 1; crel_num = 4; #1;
    chk("R9 release all", crel_ready, 1);
    go(); rm = 6;
    chk("R10 not full", q_full, 0);
    sweep();

    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule